// File: doc/BRIEF.md
# Hall-Sensor Commutation Decoder for a Three-Phase BLDC Motor

This block turns the three Hall position sensor bits of a brushless DC motor into six bridge drive requests: three for the high-side switches and three for the low-side switches. For each valid sensor code it asserts one high-side and one low-side request, picked so that current flows through the right winding pair for the rotor's current sector. It is purely combinational: no clock, no state and no reset.

Motors mount their Hall sensors at one of four electrical spacings. A 2-bit select input tells the decoder which spacing is fitted, and each spacing has its own six-code cycle and its own two illegal codes. A direction input reverses rotation by swapping every phase polarity. Codes that cannot occur for the selected spacing turn all six requests off. A separate gating stage applies speed modulation, braking, enable and overcurrent handling. The inputs are assumed to be synchronised already.

Top module: `bldc_hall_commutator`

## Requirements
- R1: `spacing_sel` chooses the sensor spacing: 0 = 60°, 1 = 120°, 2 = 240°, 3 = 300°. The sensor code is `hall_code` = {S1,S2,S3}, with S1 in bit 2.
- R2: With `dir_fwd` = 1, commutation steps 0 to 5 assert these pairs in turn: (O1,O5), (O3,O5), (O3,O4), (O2,O4), (O2,O6), (O1,O6). `drive_req` bit i is output O(i+1).
- R3: In 60° spacing, steps 0 to 5 correspond to codes 000, 100, 110, 111, 011, 001. Codes 010 and 101 are illegal.
- R4: In 120° spacing, steps 0 to 5 correspond to codes 001, 101, 100, 110, 010, 011. Codes 000 and 111 are illegal.
- R5: In 240° spacing, steps 0 to 5 correspond to codes 010, 110, 100, 101, 001, 011. Codes 000 and 111 are illegal.
- R6: In 300° spacing, steps 0 to 5 correspond to codes 011, 111, 110, 100, 000, 001. Codes 010 and 101 are illegal.
- R7: For an illegal code in the selected spacing, `drive_req` is 000000.
- R8: With `dir_fwd` = 0, a code that maps to step k asserts the pair of step (k+3) mod 6.
- R9: For every legal code, exactly one of O1..O3 and exactly one of O4..O6 is asserted.
- R10: A phase's high-side and low-side requests are never asserted together. The phase pairs are (O1,O4), (O2,O5) and (O3,O6).
- R11: The output depends only on the present inputs. The same input values always give the same `drive_req`, whatever inputs came before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| spacing_sel | input | 2 | Sensor spacing select (0 = 60°, 1 = 120°, 2 = 240°, 3 = 300°) |
| dir_fwd | input | 1 | 1 = forward rotation, 0 = reverse |
| hall_code | input | 3 | Hall sensor bits {S1,S2,S3} |
| drive_req | output | 6 | Drive requests {O6..O1}; bits 2:0 are high side, bits 5:3 are low side |

## Verification
The assertions check on every input change the rules that hold for all tables:
- no Hall code matches more than one step;
- a legal code asserts exactly one high-side and one low-side request;
- an illegal code asserts nothing;
- no phase's high and low side are ever on together.

Only the bench's scenarios can show that each spacing uses the correct code cycle, that the reverse mapping lands three steps away, and that the output carries no history. The bench sweeps every combination of select, direction and code, then applies seeded random patterns, and compares each result with its own tables.

// File: rtl/bldc_commut_pkg.sv
package bldc_commut_pkg;

    localparam int NUM_PHASES = 3;
    localparam int NUM_STEPS  = 2 * NUM_PHASES;
    localparam int STEP_W     = $clog2(NUM_STEPS);
    localparam int HALL_W     = NUM_PHASES;
    localparam int PHASE_W    = $clog2(NUM_PHASES);
    localparam int REV_OFFSET = NUM_PHASES;

    typedef enum logic [1:0] {
        SPACE_60  = 2'd0,
        SPACE_120 = 2'd1,
        SPACE_240 = 2'd2,
        SPACE_300 = 2'd3
    } spacing_e;

    typedef logic [STEP_W-1:0]  step_t;
    typedef logic [HALL_W-1:0]  hall_t;
    typedef logic [PHASE_W-1:0] phase_t;

    // low-side requests sit above the high-side requests: {O6..O4, O3..O1}
    typedef struct packed {
        logic [NUM_PHASES-1:0] lo;
        logic [NUM_PHASES-1:0] hi;
    } drive_s;

    typedef struct packed {
        logic  valid;
        step_t step;
    } sector_s;

    // sensor code seen at a given commutation step for each spacing
    function automatic hall_t hall_code_at(spacing_e sp, int step);
        hall_t c;
        c = '0;
        unique case (sp)
            SPACE_60: begin
                case (step)
                    0: c = 3'b000;  1: c = 3'b100;  2: c = 3'b110;
                    3: c = 3'b111;  4: c = 3'b011;  default: c = 3'b001;
                endcase
            end
            SPACE_120: begin
                case (step)
                    0: c = 3'b001;  1: c = 3'b101;  2: c = 3'b100;
                    3: c = 3'b110;  4: c = 3'b010;  default: c = 3'b011;
                endcase
            end
            SPACE_240: begin
                case (step)
                    0: c = 3'b010;  1: c = 3'b110;  2: c = 3'b100;
                    3: c = 3'b101;  4: c = 3'b001;  default: c = 3'b011;
                endcase
            end
            default: begin
                case (step)
                    0: c = 3'b011;  1: c = 3'b111;  2: c = 3'b110;
                    3: c = 3'b100;  4: c = 3'b000;  default: c = 3'b001;
                endcase
            end
        endcase
        return c;
    endfunction

    // phase whose high-side switch conducts during a step
    function automatic phase_t step_high_phase(step_t s);
        phase_t p;
        case (s)
            3'd0, 3'd5: p = 2'd0;
            3'd3, 3'd4: p = 2'd1;
            default:    p = 2'd2;
        endcase
        return p;
    endfunction

    // phase whose low-side switch conducts during a step
    function automatic phase_t step_low_phase(step_t s);
        phase_t p;
        case (s)
            3'd2, 3'd3: p = 2'd0;
            3'd0, 3'd1: p = 2'd1;
            default:    p = 2'd2;
        endcase
        return p;
    endfunction

    function automatic step_t step_advance(step_t s, int offset);
        int t;
        t = (int'(s) + offset) % NUM_STEPS;
        return step_t'(t);
    endfunction

endpackage

// File: rtl/hall_step_decode.sv
module hall_step_decode
    import bldc_commut_pkg::*;
(
    input  spacing_e sel,
    input  hall_t    hall,
    output sector_s  sector
);

    logic [NUM_STEPS-1:0] match;

    // one comparator per commutation step
    generate
        for (genvar k = 0; k < NUM_STEPS; k++) begin : g_step
            assign match[k] = (hall == hall_code_at(sel, k));
        end
    endgenerate

    always_comb begin
        sector.step = '0;
        for (int k = 0; k < NUM_STEPS; k++) begin
            if (match[k]) sector.step = step_t'(k);
        end
        sector.valid = |match;
    end

    always_comb begin
        if (!$isunknown({sel, hall})) begin
            // R3 R4 R5 R6
            code_unique_chk: assert ($countones(match) <= 1)
                else $error("hall code matches more than one step");
        end
    end

endmodule

// File: rtl/step_direction.sv
module step_direction
    import bldc_commut_pkg::*;
(
    input  sector_s sector_in,
    input  logic    fwd,
    output sector_s sector_out
);

    always_comb begin
        sector_out.valid = sector_in.valid;
        sector_out.step  = fwd ? sector_in.step
                               : step_advance(sector_in.step, REV_OFFSET);
    end

    always_comb begin
        if (!$isunknown({sector_in, fwd}) && sector_out.valid) begin
            // R8
            step_range_chk: assert (int'(sector_out.step) < NUM_STEPS)
                else $error("step index out of range");
        end
    end

endmodule

// File: rtl/drive_encode.sv
module drive_encode
    import bldc_commut_pkg::*;
(
    input  sector_s sector,
    output drive_s  drv
);

    phase_t hi_ph;
    phase_t lo_ph;

    assign hi_ph = step_high_phase(sector.step);
    assign lo_ph = step_low_phase(sector.step);

    generate
        for (genvar p = 0; p < NUM_PHASES; p++) begin : g_phase
            assign drv.hi[p] = sector.valid && (hi_ph == phase_t'(p));
            assign drv.lo[p] = sector.valid && (lo_ph == phase_t'(p));
        end
    endgenerate

    always_comb begin
        if (!$isunknown(sector)) begin
            // R9
            one_pair_chk: assert (!sector.valid ||
                                  ($countones(drv.hi) == 1 && $countones(drv.lo) == 1))
                else $error("legal step without exactly one pair");
            // R10
            no_shoot_chk: assert ((drv.hi & drv.lo) == '0)
                else $error("same phase driven high and low");
            // R7
            idle_off_chk: assert (sector.valid || drv == '0)
                else $error("illegal code drives outputs");
        end
    end

endmodule

// File: rtl/bldc_hall_commutator.sv
module bldc_hall_commutator
    import bldc_commut_pkg::*;
(
    input  logic [1:0] spacing_sel,
    input  logic       dir_fwd,
    input  logic [2:0] hall_code,
    output logic [5:0] drive_req
);

    sector_s raw_sector;
    sector_s dir_sector;
    drive_s  drv;

    hall_step_decode u_decode (
        .sel    (spacing_e'(spacing_sel)),
        .hall   (hall_code),
        .sector (raw_sector)
    );

    step_direction u_dir (
        .sector_in  (raw_sector),
        .fwd        (dir_fwd),
        .sector_out (dir_sector)
    );

    drive_encode u_enc (
        .sector (dir_sector),
        .drv    (drv)
    );

    assign drive_req = drv;

    always_comb begin
        if (!$isunknown({spacing_sel, dir_fwd, hall_code})) begin
            // R9
            top_count_chk: assert ($countones(drive_req) == 0 || $countones(drive_req) == 2)
                else $error("drive request count is neither 0 nor 2");
        end
    end

endmodule

// File: tb/bldc_hall_commutator_tb.sv
module bldc_hall_commutator_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] sel;
    logic       fwd;
    logic [2:0] hall;
    logic [5:0] drv;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    bldc_hall_commutator u_dut (
        .spacing_sel (sel),
        .dir_fwd     (fwd),
        .hall_code   (hall),
        .drive_req   (drv)
    );

    // reference code cycles per spacing, steps 0..5
    function automatic logic [2:0] ref_code(int m, int k);
        logic [2:0] t60[6]  = '{3'b000, 3'b100, 3'b110, 3'b111, 3'b011, 3'b001};
        logic [2:0] t120[6] = '{3'b001, 3'b101, 3'b100, 3'b110, 3'b010, 3'b011};
        logic [2:0] t240[6] = '{3'b010, 3'b110, 3'b100, 3'b101, 3'b001, 3'b011};
        logic [2:0] t300[6] = '{3'b011, 3'b111, 3'b110, 3'b100, 3'b000, 3'b001};
        case (m)
            0: return t60[k];
            1: return t120[k];
            2: return t240[k];
            default: return t300[k];
        endcase
    endfunction

    // pair per forward step, as {O6..O1}
    function automatic logic [5:0] ref_pair(int k);
        logic [5:0] p[6] = '{6'b010001, 6'b010100, 6'b001100,
                             6'b001010, 6'b100010, 6'b100001};
        return p[k];
    endfunction

    function automatic logic [5:0] ref_drive(int m, bit f, logic [2:0] h);
        for (int k = 0; k < 6; k++) begin
            if (ref_code(m, k) == h) return ref_pair(f ? k : (k + 3) % 6);
        end
        return 6'b000000;
    endfunction

    function automatic string req_tag(int m, bit f, logic [2:0] h);
        if (ref_drive(m, f, h) == 6'b0) return "R7";
        if (!f) return "R8";
        case (m)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(string tag, logic [5:0] act, logic [5:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s sel=%0d fwd=%0b hall=%b actual=%b expected=%b",
                     tag, sel, fwd, hall, act, exp);
        end
    endtask

    task automatic apply(int m, bit f, logic [2:0] h);
        @(negedge clk);
        sel  = 2'(m);
        fwd  = f;
        hall = h;
        #2;
        check(req_tag(m, f, h), drv, ref_drive(m, f, h));
        // R9 R10 structural checks at the ports
        checks++;
        if (drv != 0 && !($countones(drv[2:0]) == 1 && $countones(drv[5:3]) == 1)) begin
            errors++;
            $display("FAIL R9 actual=%b expected=one high and one low", drv);
        end
        checks++;
        if ((drv[2:0] & drv[5:3]) != 3'b000) begin
            errors++;
            $display("FAIL R10 actual=%b expected=no phase overlap", drv);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d cycles expected=completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        sel = 2'd0; fwd = 1'b1; hall = 3'b010;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        #2;
        // idle state: illegal code in 60 deg spacing gives no drive (R7)
        check("R7", drv, 6'b000000);

        // R1 R2: forward step sequence in 60 deg spacing
        apply(0, 1'b1, 3'b000);
        check("R2", drv, 6'b010001);
        apply(0, 1'b1, 3'b100);
        check("R2", drv, 6'b010100);
        // R1: select value 3 is 300 deg, code 000 is step 4 -> (O2,O6)
        apply(3, 1'b1, 3'b000);
        check("R1", drv, 6'b100010);
        // R8: reverse of step 0 in 120 deg gives (O2,O4)
        apply(1, 1'b0, 3'b001);
        check("R8", drv, 6'b001010);

        // exhaustive sweep
        for (int m = 0; m < 4; m++)
            for (int f = 0; f < 2; f++)
                for (int h = 0; h < 8; h++)
                    apply(m, f[0], 3'(h));

        // R11: history independence, revisit one point after others
        apply(2, 1'b1, 3'b101);
        apply(0, 1'b0, 3'b111);
        apply(2, 1'b1, 3'b101);
        check("R11", drv, 6'b001010);

        // seeded random patterns
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 400; i++) begin
            apply(int'($urandom % 4), bit'($urandom % 2), 3'($urandom % 8));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule